// File: doc/BRIEF.md
# Compare-and-Branch Condition Unit

This unit resolves conditional branches under a deferred-compare model. A compare operation captures two register values into a pair of condition operand registers. No flag bits are formed at that point. A later branch operation selects one of ten relations, some signed and some unsigned, and applies it to the captured pair. From that result it produces the next program counter.

A branch target is relative to the address of the halfword that follows the branch. It is formed from a sign-extended 10-bit offset counted in halfwords. A condition code outside the defined range is flagged as illegal and leaves the program counter where it was. Each branch strobe is answered by a registered result one clock later. Fetch and the register file sit outside the unit.

Top module: `cbu_branch_unit`

## Requirements
- R1: After synchronous reset, res_valid, res_taken and res_illegal are 0, res_next_pc is 0 and both condition operands are 0, so a branch on code 0x0 issued with no prior compare is taken.
- R2: A cycle with cmp_en high and br_en low loads cmp_lhs into operand a and cmp_rhs into operand b. It changes nothing else: res_valid, res_taken and res_illegal are 0 in the following cycle and res_next_pc holds its value. Branches never modify the operands.
- R3: A taken branch gives res_next_pc = cur_pc + 2 + 2 * sext(br_offset), where br_offset is a 10-bit two's-complement halfword count (-512 to +511), computed modulo 2^32.
- R4: A legal branch that is not taken gives res_next_pc = cur_pc + 2.
- R5: Signed and equality codes compare a against b: 0x0 equal, 0x1 not equal, 0x2 a<b, 0x3 a>b, 0x6 a>=b, 0x7 a<=b (signed compares use two's complement).
- R6: Unsigned codes compare a against b: 0x4 a<b, 0x5 a>b, 0x8 a>=b, 0x9 a<=b.
- R7: Codes 0xA to 0xF give res_illegal = 1, res_taken = 0 and res_next_pc = cur_pc.
- R8: When cmp_en and br_en are high in the same cycle, the branch is evaluated on the newly presented compare operands.
- R9: res_valid is 1 exactly in the cycle after a cycle with br_en high. res_taken and res_illegal are 0 whenever res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en | input | 1 | Compare strobe |
| cmp_lhs | input | DATA_W | Value captured as operand a |
| cmp_rhs | input | DATA_W | Value captured as operand b |
| br_en | input | 1 | Branch strobe |
| br_cond | input | 4 | Relation code |
| br_offset | input | OFF_W | Signed halfword displacement |
| cur_pc | input | PC_W | Address of the branch |
| res_valid | output | 1 | Result of the previous cycle's branch is present |
| res_taken | output | 1 | Branch taken |
| res_illegal | output | 1 | Condition code undefined |
| res_next_pc | output | PC_W | Next program counter |

## Verification
The bench builds the unit with its default widths: 32-bit operands, a 32-bit program counter and a 10-bit offset. At these widths the offset field reaches its extremes of -512 and +511 halfwords. Operands that differ only in bit 31 separate every signed relation from its unsigned counterpart. Program counters near 0 and near 0xFFFFFFFF exercise wrap-around of the target addition.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    // relation selector values; their encoding is decoded directly
    typedef enum logic [3:0] {
        REL_EQ  = 4'h0,
        REL_NE  = 4'h1,
        REL_SLT = 4'h2,
        REL_SGT = 4'h3,
        REL_ULT = 4'h4,
        REL_UGT = 4'h5,
        REL_SGE = 4'h6,
        REL_SLE = 4'h7,
        REL_UGE = 4'h8,
        REL_ULE = 4'h9
    } rel_e;

    localparam logic [3:0] REL_LAST = 4'h9;

    typedef struct packed {
        logic taken;
        logic illegal;
    } verdict_t;

    function automatic logic rel_defined(input logic [3:0] code);
        return code <= REL_LAST;
    endfunction

endpackage

// File: rtl/cbu_operand_latch.sv
module cbu_operand_latch #(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [1:0][DATA_W-1:0] din,
    output logic [1:0][DATA_W-1:0] eff
);
    localparam int N_OPS = 2;

    logic [N_OPS-1:0][DATA_W-1:0] held;

    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        always_ff @(posedge clk) begin
            if (rst)
                held[i] <= '0;
            else if (load)
                held[i] <= din[i];
        end
        // compare-first: a same-cycle load is visible to the evaluator
        assign eff[i] = load ? din[i] : held[i];
    end
endmodule

// File: rtl/cbu_relation_eval.sv
module cbu_relation_eval
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output verdict_t          verdict
);
    logic eq, lt_u, lt_s;

    always_comb begin
        eq   = (opa == opb);
        lt_u = (opa < opb);
        lt_s = ($signed(opa) < $signed(opb));
    end

    always_comb begin
        verdict.illegal = !rel_defined(code);
        unique case (code)
            REL_EQ:  verdict.taken = eq;
            REL_NE:  verdict.taken = !eq;
            REL_SLT: verdict.taken = lt_s;
            REL_SGT: verdict.taken = !lt_s && !eq;
            REL_SGE: verdict.taken = !lt_s;
            REL_SLE: verdict.taken = lt_s || eq;
            REL_ULT: verdict.taken = lt_u;
            REL_UGT: verdict.taken = !lt_u && !eq;
            REL_UGE: verdict.taken = !lt_u;
            REL_ULE: verdict.taken = lt_u || eq;
            default: verdict.taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/cbu_target_calc.sv
module cbu_target_calc
    import cbu_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int OFF_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  verdict_t         verdict,
    output logic [PC_W-1:0]  next_pc
);
    localparam int           EXT_W = PC_W - OFF_W - 1;
    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(2);

    logic [PC_W-1:0] fall_through;
    logic [PC_W-1:0] disp;

    always_comb begin
        fall_through = pc + INSN_BYTES;
        disp         = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
        if (verdict.illegal)
            next_pc = pc;
        else if (verdict.taken)
            next_pc = fall_through + disp;
        else
            next_pc = fall_through;
    end
endmodule

// File: rtl/cbu_branch_unit.sv
module cbu_branch_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int OFF_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] cmp_lhs,
    input  logic [DATA_W-1:0] cmp_rhs,
    input  logic              br_en,
    input  logic [3:0]        br_cond,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [PC_W-1:0]   cur_pc,
    output logic              res_valid,
    output logic              res_taken,
    output logic              res_illegal,
    output logic [PC_W-1:0]   res_next_pc
);
    logic [1:0][DATA_W-1:0] ops;
    verdict_t               verdict;
    logic [PC_W-1:0]        npc;

    cbu_operand_latch #(.DATA_W(DATA_W)) u_ops (
        .clk  (clk),
        .rst  (rst),
        .load (cmp_en),
        .din  ({cmp_rhs, cmp_lhs}),
        .eff  (ops)
    );

    cbu_relation_eval #(.DATA_W(DATA_W)) u_rel (
        .code    (br_cond),
        .opa     (ops[0]),
        .opb     (ops[1]),
        .verdict (verdict)
    );

    cbu_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc      (cur_pc),
        .offset  (br_offset),
        .verdict (verdict),
        .next_pc (npc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_taken   <= 1'b0;
            res_illegal <= 1'b0;
            res_next_pc <= '0;
        end else begin
            res_valid <= br_en;
            if (br_en) begin
                res_taken   <= verdict.taken;
                res_illegal <= verdict.illegal;
                res_next_pc <= npc;
            end else begin
                res_taken   <= 1'b0;
                res_illegal <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cbu_branch_chk.sv
module cbu_branch_chk #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             br_en,
    input logic [3:0]       br_cond,
    input logic [OFF_W-1:0] br_offset,
    input logic [PC_W-1:0]  cur_pc,
    input logic             res_valid,
    input logic             res_taken,
    input logic             res_illegal,
    input logic [PC_W-1:0]  res_next_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(2);

    // R9
    result_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        br_en |=> res_valid);

    // R9
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (rst)
        !br_en |=> (!res_valid && !res_taken && !res_illegal));

    // R7
    illegal_holds_pc_chk: assert property (@(posedge clk) disable iff (rst)
        res_illegal |-> (!res_taken && res_next_pc == $past(cur_pc) && $past(br_cond) > 4'h9));

    // R4
    fall_through_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_taken && !res_illegal) |-> res_next_pc == $past(cur_pc) + STEP);

    // R3
    taken_target_chk: assert property (@(posedge clk) disable iff (rst)
        res_taken |-> res_next_pc ==
            $past(cur_pc) + STEP + (PC_W'($signed($past(br_offset))) << 1));
endmodule

bind cbu_branch_unit cbu_branch_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .br_en       (br_en),
    .br_cond     (br_cond),
    .br_offset   (br_offset),
    .cur_pc      (cur_pc),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .res_illegal (res_illegal),
    .res_next_pc (res_next_pc)
);

// File: tb/tb_cbu_branch_unit.sv
module tb_cbu_branch_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_en = 1'b0;
    logic [31:0] cmp_lhs = '0;
    logic [31:0] cmp_rhs = '0;
    logic        br_en = 1'b0;
    logic [3:0]  br_cond = '0;
    logic [9:0]  br_offset = '0;
    logic [31:0] cur_pc = '0;
    logic        res_valid, res_taken, res_illegal;
    logic [31:0] res_next_pc;

    int    checks = 0;
    int    errors = 0;
    bit    armed  = 0;
    bit    done   = 0;
    string tag    = "R1";

    // reference model state
    logic [31:0] ma = '0, mb = '0;
    logic        e_v = 0, e_t = 0, e_i = 0;
    logic [31:0] e_pc = '0;
    string       e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    cbu_branch_unit dut (
        .clk(clk), .rst(rst), .cmp_en(cmp_en), .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
        .br_en(br_en), .br_cond(br_cond), .br_offset(br_offset), .cur_pc(cur_pc),
        .res_valid(res_valid), .res_taken(res_taken), .res_illegal(res_illegal),
        .res_next_pc(res_next_pc)
    );

    function automatic bit relation(input int code, input logic [31:0] a, input logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'(a);
        longint ub = longint'(b);
        case (code)
            0: return ua == ub;
            1: return ua != ub;
            2: return sa < sb;
            3: return sa > sb;
            4: return ua < ub;
            5: return ua > ub;
            6: return sa >= sb;
            7: return sa <= sb;
            8: return ua >= ub;
            9: return ua <= ub;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        armed <= 1'b1;
        if (rst) begin
            ma = '0; mb = '0;
            e_v = 0; e_t = 0; e_i = 0; e_pc = '0;
            e_tag = "R1";
        end else begin
            if (cmp_en) begin
                ma = cmp_lhs;
                mb = cmp_rhs;
            end
            e_tag = tag;
            if (br_en) begin
                int d;
                e_v = 1;
                d = br_offset[9] ? int'(br_offset) - 1024 : int'(br_offset);
                if (br_cond > 9) begin
                    e_i = 1; e_t = 0; e_pc = cur_pc;
                end else begin
                    e_i = 0;
                    e_t = relation(int'(br_cond), ma, mb);
                    e_pc = e_t ? cur_pc + 32'd2 + 32'(2 * d) : cur_pc + 32'd2;
                end
            end else begin
                e_v = 0; e_t = 0; e_i = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (res_valid !== e_v || res_taken !== e_t || res_illegal !== e_i || res_next_pc !== e_pc) begin
                errors++;
                $display("FAIL %s: got v=%b t=%b i=%b pc=%h, expected v=%b t=%b i=%b pc=%h",
                         e_tag, res_valid, res_taken, res_illegal, res_next_pc,
                         e_v, e_t, e_i, e_pc);
            end
        end
    end

    task automatic step(input bit c, input logic [31:0] a, input logic [31:0] b,
                        input bit br, input logic [3:0] cond, input logic [9:0] off,
                        input logic [31:0] pc, input string t);
        @(negedge clk);
        cmp_en = c; cmp_lhs = a; cmp_rhs = b;
        br_en = br; br_cond = cond; br_offset = off; cur_pc = pc;
        tag = t;
    endtask

    task automatic idle(input string t);
        step(0, '0, '0, 0, '0, '0, cur_pc, t);
    endtask

    // every code on the current operand pair
    task automatic sweep(input logic [31:0] pc, input logic [9:0] off);
        for (int c = 0; c < 16; c++) begin
            string t;
            t = (c > 9) ? "R7" : ((c == 4 || c == 5 || c == 8 || c == 9) ? "R6" : "R5");
            step(0, '0, '0, 1, 4'(c), off, pc, t);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        tag = "R1";
        idle("R1");
        // R1: zero operands, equal-branch taken
        step(0, '0, '0, 1, 4'h0, 10'd4, 32'h100, "R1");
        idle("R1");

        // R2: compare-only cycle, no result, next pc held
        step(1, 32'd5, 32'd7, 0, '0, '0, 32'h200, "R2");
        idle("R2");
        sweep(32'h0000_1000, 10'd3);
        // R2: branches left the operands unchanged
        step(0, '0, '0, 1, 4'h2, 10'd1, 32'h40, "R2");

        // operands differing only in bit 31 (R5, R6)
        step(1, 32'h8000_0000, 32'h0000_0000, 0, '0, '0, 32'h0, "R2");
        sweep(32'h0000_2000, 10'h3F0);
        step(1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, '0, '0, 32'h0, "R2");
        sweep(32'h0000_3000, 10'd9);
        // equal operands
        step(1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, '0, '0, 32'h0, "R2");
        sweep(32'h0000_4000, 10'd1);

        // R3: offset extremes, taken via code 0 on equal operands
        step(0, '0, '0, 1, 4'h0, 10'h200, 32'h0000_1000, "R3");
        step(0, '0, '0, 1, 4'h0, 10'h1FF, 32'h0000_1000, "R3");
        step(0, '0, '0, 1, 4'h0, 10'h200, 32'h0000_0010, "R3");
        step(0, '0, '0, 1, 4'h0, 10'h1FF, 32'hFFFF_FFF0, "R3");
        // R4: not-taken wrap
        step(0, '0, '0, 1, 4'h1, 10'h1FF, 32'hFFFF_FFFE, "R4");
        // R7: illegal keeps pc
        step(0, '0, '0, 1, 4'hA, 10'h1FF, 32'h0000_0ABC, "R7");
        step(0, '0, '0, 1, 4'hF, 10'h200, 32'h0000_0ABE, "R7");

        // R8: compare and branch together use the new pair
        step(1, 32'd1, 32'd2, 1, 4'h4, 10'd8, 32'h500, "R8");
        step(1, 32'd9, 32'd2, 1, 4'h4, 10'd8, 32'h600, "R8");
        step(1, 32'hFFFF_FFFF, 32'd1, 1, 4'h2, 10'd8, 32'h700, "R8");
        idle("R9");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = ($urandom_range(0, 3) == 0) ? a ^ 32'h8000_0000 : $urandom;
            step(1'($urandom_range(0, 1)), a, b, 1'($urandom_range(0, 1)),
                 4'($urandom_range(0, 15)), 10'($urandom), $urandom, "R9");
        end
        idle("R9");
        idle("R9");
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule